// File: doc/BRIEF.md
# Link Bring-Up Sequencer

This block walks a packet-interface link from reset to the operational state. After a request is accepted, it runs a fixed series of phases. The first four phases are handshakes with subordinate units: self-test, calendar programming, clock detection and training. Each handshake raises a one-hot request and waits for a done pulse, which may carry an error flag. The fifth phase, calendar synchronisation, is handled inside the block. The sixth phase turns the interface on. A restart request skips calendar programming. The two mode bits decide which half of the link, receive or transmit, takes part in the enable steps.

When the sequence ends, the block shows either a link-up flag or a 3-bit code that names the phase that failed. The block also drives several configuration outputs:
- a mask that holds error reporting off during self-test;
- the clock-delay setting;
- the latched calendar length;
- interface and status enables for each half of the link.

Top module: `link_bringup_seq`

## Requirements
- R1: After `startReq` is accepted, `stepReq` is one-hot and requests, in order, bit 0 (self-test), bit 1 (calendar setup), bit 2 (clock detect) and bit 3 (training). A step ends on the clock edge where `stepDone` is high. Calendar sync follows, then interface-up, and then `linkUp` rises and `busy` falls.
- R2: After `restartReq` is accepted, the sequence is the same except that `stepReq` bit 1 is never raised. Clock detect follows self-test directly.
- R3: If `stepDone` comes with `stepErr` high, the sequence stops at once. `errCode` then holds the phase index: 1 self-test, 2 calendar setup, 3 clock detect, 4 training, 5 calendar sync. No later step is requested, `busy` falls and `linkUp` stays 0. An `errCode` of 0 means no error.
- R4: `mode` is latched when a request is accepted. Bit 0 marks the receive half as active and bit 1 marks the transmit half. In the interface-up phase, each active half sets its interface enable (`rxIfEn`, `txIfEn`) and an inactive half leaves its enable at 0.
- R5: `errMask` is high exactly while the self-test request is raised.
- R6: `clkDelay` is 0 after reset. It becomes mid-scale (16 with the default width of 5) when self-test completes without error.
- R7: In calendar sync, an active receive half sets `rxIfEn` and `rxStatEn` together. An active transmit half sets `txStatEn` and then waits for `calLocked` before the sequence goes on.
- R8: If the transmit half is active and `calLocked` stays low for `SYNC_TIMEOUT` cycles of calendar sync, the sequence fails with `errCode` 5. In that case `txStatEn` is 1 and `txIfEn` is 0.
- R9: A start or restart request that arrives while `busy` is high is ignored, and the step in progress keeps its request.
- R10: `calLen` takes `portCount` when a request is accepted and holds that value while the port changes afterwards.
- R11: After reset, `busy`, `linkUp`, `errCode`, `stepReq`, `errMask` and all four enables are 0.
- R12: An accepted request clears `errCode`, `linkUp` and all four enables in the cycle it raises `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Full bring-up request; takes priority over restart |
| restartReq | input | 1 | Shortened bring-up request (no calendar setup) |
| mode | input | 2 | Bit 0 receive active, bit 1 transmit active |
| portCount | input | PORTW | Number of calendar ports |
| stepDone | input | 1 | Current handshake step finished |
| stepErr | input | 1 | Qualifies stepDone as a failure |
| calLocked | input | 1 | Transmit calendar lock seen |
| stepReq | output | 4 | One-hot handshake step request |
| errMask | output | 1 | Error reporting masked during self-test |
| clkDelay | output | CDW | Clock delay setting |
| calLen | output | PORTW | Latched calendar length |
| rxStatEn | output | 1 | Receive status send enable |
| rxIfEn | output | 1 | Receive interface enable |
| txStatEn | output | 1 | Transmit status receiver enable |
| txIfEn | output | 1 | Transmit interface enable |
| busy | output | 1 | Sequence in progress |
| linkUp | output | 1 | Link operational |
| errCode | output | 3 | Failed phase index, 0 if none |

## Verification
The hardest case to reach is the calendar-sync timeout, because it only happens when all four handshakes have already succeeded. The bench serves every step cleanly in transmit-only mode and holds `calLocked` low. It then checks that the sequence is still busy halfway through the window and that it fails with code 5 afterwards. Ignoring a request while busy is checked in a similar way. The bench fires both request inputs while clock detection is pending and confirms that the same step request is still shown.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
  // Encoding equals the phase index reported on failure.
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_SELFTEST = 3'd1,
    ST_CALSET   = 3'd2,
    ST_CLKDET   = 3'd3,
    ST_TRAIN    = 3'd4,
    ST_CALSYNC  = 3'd5,
    ST_UP       = 3'd6
  } phase_e;

  typedef struct packed {
    logic accept;      // new request taken: latch config, clear enables
    logic selfTestOk;  // self-test finished cleanly
    logic syncEn;      // in calendar sync phase
    logic upEn;        // in interface-up phase
  } ctl_strobe_t;

  localparam int NUM_HS = 4;
endpackage

// File: rtl/lbs_ctrl.sv
module lbs_ctrl
  import lbs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              restartReq,
  input  logic              stepDone,
  input  logic              stepErr,
  input  logic              txAct,
  input  logic              calLocked,
  input  logic              syncTimeout,
  output logic [NUM_HS-1:0] stepReq,
  output logic              busy,
  output logic              linkUp,
  output logic [2:0]        errCode,
  output logic              errMask,
  output ctl_strobe_t       strb
);
  phase_e state, stateNxt;
  logic   fullRun;
  logic   accept;
  logic   hsPhase;
  logic   failNow;

  assign busy    = (state != ST_IDLE);
  assign accept  = !busy && (startReq || restartReq);
  assign errMask = (state == ST_SELFTEST);
  assign hsPhase = (state == ST_SELFTEST) || (state == ST_CALSET) ||
                   (state == ST_CLKDET)   || (state == ST_TRAIN);
  assign failNow = (hsPhase && stepDone && stepErr) ||
                   ((state == ST_CALSYNC) && txAct && !calLocked && syncTimeout);

  for (genvar i = 0; i < NUM_HS; i++) begin : g_req
    assign stepReq[i] = (state == phase_e'(3'(i + 1)));
  end

  always_comb begin
    stateNxt = state;
    if (failNow) begin
      stateNxt = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:     if (accept) stateNxt = ST_SELFTEST;
        ST_SELFTEST: if (stepDone) stateNxt = fullRun ? ST_CALSET : ST_CLKDET;
        ST_CALSET:   if (stepDone) stateNxt = ST_CLKDET;
        ST_CLKDET:   if (stepDone) stateNxt = ST_TRAIN;
        ST_TRAIN:    if (stepDone) stateNxt = ST_CALSYNC;
        ST_CALSYNC:  if (!txAct || calLocked) stateNxt = ST_UP;
        ST_UP:       stateNxt = ST_IDLE;
        default:     stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      fullRun <= 1'b0;
      errCode <= 3'd0;
      linkUp  <= 1'b0;
    end else begin
      state <= stateNxt;
      if (accept) begin
        fullRun <= startReq;
        errCode <= 3'd0;
        linkUp  <= 1'b0;
      end else if (failNow) begin
        errCode <= state;
      end else if (state == ST_UP) begin
        linkUp <= 1'b1;
      end
    end
  end

  always_comb begin
    strb.accept     = accept;
    strb.selfTestOk = (state == ST_SELFTEST) && stepDone && !stepErr;
    strb.syncEn     = (state == ST_CALSYNC);
    strb.upEn       = (state == ST_UP);
  end
endmodule

// File: rtl/lbs_dp.sv
module lbs_dp
  import lbs_pkg::*;
#(
  parameter int PORTW        = 5,
  parameter int CDW          = 5,
  parameter int SYNC_TIMEOUT = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctl_strobe_t      strb,
  input  logic [1:0]       mode,
  input  logic [PORTW-1:0] portCount,
  output logic             txAct,
  output logic             syncTimeout,
  output logic [CDW-1:0]   clkDelay,
  output logic [PORTW-1:0] calLen,
  output logic             rxStatEn,
  output logic             rxIfEn,
  output logic             txStatEn,
  output logic             txIfEn
);
  localparam int            CW     = (SYNC_TIMEOUT > 2) ? $clog2(SYNC_TIMEOUT) : 1;
  localparam logic [CW-1:0] CNT_TOP = CW'(SYNC_TIMEOUT - 1);
  localparam logic [CDW-1:0] CD_MID = CDW'(1) << (CDW - 1);

  logic [1:0]    modeQ;
  logic [1:0]    ifEn, statEn;
  logic [CW-1:0] syncCnt;

  assign txAct       = modeQ[1];
  assign syncTimeout = (syncCnt == CNT_TOP);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ    <= 2'b00;
      calLen   <= '0;
      clkDelay <= '0;
      syncCnt  <= '0;
    end else begin
      if (strb.accept) begin
        modeQ  <= mode;
        calLen <= portCount;
      end
      if (strb.selfTestOk) clkDelay <= CD_MID;
      if (!strb.syncEn)         syncCnt <= '0;
      else if (!syncTimeout)    syncCnt <= syncCnt + 1'b1;
    end
  end

  // Half 0 = receive, half 1 = transmit. Receive enables its interface in
  // sync already; transmit only arms its status receiver there.
  for (genvar h = 0; h < 2; h++) begin : g_half
    localparam bit IF_IN_SYNC = (h == 0);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        ifEn[h]   <= 1'b0;
        statEn[h] <= 1'b0;
      end else if (strb.accept) begin
        ifEn[h]   <= 1'b0;
        statEn[h] <= 1'b0;
      end else if (modeQ[h]) begin
        if (strb.syncEn) begin
          statEn[h] <= 1'b1;
          if (IF_IN_SYNC) ifEn[h] <= 1'b1;
        end
        if (strb.upEn) ifEn[h] <= 1'b1;
      end
    end
  end

  assign rxIfEn   = ifEn[0];
  assign rxStatEn = statEn[0];
  assign txIfEn   = ifEn[1];
  assign txStatEn = statEn[1];
endmodule

// File: rtl/link_bringup_seq.sv
module link_bringup_seq
  import lbs_pkg::*;
#(
  parameter int PORTW        = 5,
  parameter int CDW          = 5,
  parameter int SYNC_TIMEOUT = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              restartReq,
  input  logic [1:0]        mode,
  input  logic [PORTW-1:0]  portCount,
  input  logic              stepDone,
  input  logic              stepErr,
  input  logic              calLocked,
  output logic [NUM_HS-1:0] stepReq,
  output logic              errMask,
  output logic [CDW-1:0]    clkDelay,
  output logic [PORTW-1:0]  calLen,
  output logic              rxStatEn,
  output logic              rxIfEn,
  output logic              txStatEn,
  output logic              txIfEn,
  output logic              busy,
  output logic              linkUp,
  output logic [2:0]        errCode
);
  ctl_strobe_t strb;
  logic        txAct;
  logic        syncTimeout;

  lbs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .restartReq(restartReq),
    .stepDone(stepDone), .stepErr(stepErr), .txAct(txAct),
    .calLocked(calLocked), .syncTimeout(syncTimeout), .stepReq(stepReq),
    .busy(busy), .linkUp(linkUp), .errCode(errCode), .errMask(errMask),
    .strb(strb)
  );

  lbs_dp #(.PORTW(PORTW), .CDW(CDW), .SYNC_TIMEOUT(SYNC_TIMEOUT)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .mode(mode), .portCount(portCount),
    .txAct(txAct), .syncTimeout(syncTimeout), .clkDelay(clkDelay),
    .calLen(calLen), .rxStatEn(rxStatEn), .rxIfEn(rxIfEn),
    .txStatEn(txStatEn), .txIfEn(txIfEn)
  );
endmodule

// File: rtl/lbs_checker.sv
module lbs_checker #(
  parameter int CDW = 5
) (
  input logic           clk,
  input logic           rstN,
  input logic [3:0]     stepReq,
  input logic           stepDone,
  input logic           stepErr,
  input logic           errMask,
  input logic [CDW-1:0] clkDelay,
  input logic           busy,
  input logic           linkUp,
  input logic [2:0]     errCode,
  input logic           txIfEn,
  input logic           txStatEn
);
  localparam logic [CDW-1:0] MID = CDW'(1) << (CDW - 1);

  a_r1_onehot_req: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stepReq));

  a_r1_req_needs_busy: assert property (@(posedge clk) disable iff (!rstN)
    (stepReq != 4'b0) |-> busy);

  a_r3_abort: assert property (@(posedge clk) disable iff (!rstN)
    (stepReq != 4'b0 && stepDone && stepErr) |=> (!busy && errCode != 3'd0 && !linkUp));

  a_r5_mask_selftest: assert property (@(posedge clk) disable iff (!rstN)
    errMask == stepReq[0]);

  a_r6_mid_delay: assert property (@(posedge clk) disable iff (!rstN)
    (stepReq[0] && stepDone && !stepErr) |=> (clkDelay == MID));

  a_r7_tx_if_after_stat: assert property (@(posedge clk) disable iff (!rstN)
    txIfEn |-> txStatEn);

  a_r9_hold_step: assert property (@(posedge clk) disable iff (!rstN)
    (stepReq != 4'b0 && !stepDone) |=> $stable(stepReq));

  a_r4_up_clean: assert property (@(posedge clk) disable iff (!rstN)
    linkUp |-> (!busy && errCode == 3'd0));

  a_r12_clear_on_accept: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (!linkUp && errCode == 3'd0 && !txIfEn));
endmodule

bind link_bringup_seq lbs_checker #(.CDW(CDW)) u_chk (
  .clk(clk), .rstN(rstN), .stepReq(stepReq), .stepDone(stepDone),
  .stepErr(stepErr), .errMask(errMask), .clkDelay(clkDelay), .busy(busy),
  .linkUp(linkUp), .errCode(errCode), .txIfEn(txIfEn), .txStatEn(txStatEn)
);

// File: tb/link_bringup_seq_tb.sv
module link_bringup_seq_tb;
  localparam int PERIOD = 10;
  localparam int PORTW  = 5;
  localparam int CDW    = 5;
  localparam int SYNC_TO = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 0, restartReq = 0, stepDone = 0, stepErr = 0, calLocked = 0;
  logic [1:0] mode = 2'b00;
  logic [PORTW-1:0] portCount = '0;
  logic [3:0] stepReq;
  logic errMask, rxStatEn, rxIfEn, txStatEn, txIfEn, busy, linkUp;
  logic [CDW-1:0] clkDelay;
  logic [PORTW-1:0] calLen;
  logic [2:0] errCode;

  int nChk = 0, nFail = 0, calSeen = 0;
  bit  done = 0;

  always #(PERIOD/2) clk = ~clk;

  link_bringup_seq #(.PORTW(PORTW), .CDW(CDW), .SYNC_TIMEOUT(SYNC_TO)) u_dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .restartReq(restartReq),
    .mode(mode), .portCount(portCount), .stepDone(stepDone), .stepErr(stepErr),
    .calLocked(calLocked), .stepReq(stepReq), .errMask(errMask),
    .clkDelay(clkDelay), .calLen(calLen), .rxStatEn(rxStatEn), .rxIfEn(rxIfEn),
    .txStatEn(txStatEn), .txIfEn(txIfEn), .busy(busy), .linkUp(linkUp),
    .errCode(errCode)
  );

  always @(posedge clk) if (stepReq[1]) calSeen++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic request(input bit full, input logic [1:0] m, input int pc);
    @(negedge clk);
    mode = m; portCount = PORTW'(pc);
    if (full) startReq = 1; else restartReq = 1;
    @(negedge clk);
    startReq = 0; restartReq = 0;
  endtask

  // Wait for any step request, check it is the expected one, then answer.
  task automatic serve(input int idx, input bit err, input string tag);
    int n = 0;
    while (stepReq == 4'b0 && n < 200) begin @(negedge clk); n++; end
    chk(stepReq == 4'(1 << idx), tag, stepReq, 1 << idx);
    if (idx == 0) chk(errMask == 1'b1, "R5 mask during self-test", errMask, 1);
    repeat (2) @(negedge clk);
    stepDone = 1; stepErr = err;
    @(negedge clk);
    stepDone = 0; stepErr = 0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busy && n < 500) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset();
    chk(!busy && !linkUp && errCode == 0, "R11 status after reset", {busy, linkUp, errCode}, 0);
    chk(stepReq == 0 && !errMask, "R11 requests after reset", stepReq, 0);
    chk({rxStatEn, rxIfEn, txStatEn, txIfEn} == 0, "R11 enables after reset",
        {rxStatEn, rxIfEn, txStatEn, txIfEn}, 0);
    chk(clkDelay == 0, "R6 delay after reset", clkDelay, 0);
  endtask

  task automatic t_full_duplex();
    calLocked = 1;
    request(1, 2'b11, 12);
    portCount = 5'd3;
    chk(calLen == 12, "R10 calLen latched", calLen, 12);
    serve(0, 0, "R1 self-test first");
    chk(clkDelay == 16, "R6 mid-scale delay", clkDelay, 16);
    chk(errMask == 0, "R5 mask released", errMask, 0);
    serve(1, 0, "R1 calendar second");
    serve(2, 0, "R1 clock detect third");
    serve(3, 0, "R1 training fourth");
    waitIdle();
    chk(linkUp && errCode == 0, "R1 link up", {linkUp, errCode}, 8);
    chk({rxStatEn, rxIfEn, txStatEn, txIfEn} == 4'b1111, "R4 R7 duplex enables",
        {rxStatEn, rxIfEn, txStatEn, txIfEn}, 15);
    chk(calLen == 12, "R10 calLen held", calLen, 12);
  endtask

  task automatic t_restart_rx();
    calSeen = 0;
    request(0, 2'b01, 4);
    chk(!linkUp && busy && {rxIfEn, txIfEn} == 0, "R12 clear on restart",
        {busy, linkUp, rxIfEn, txIfEn}, 8);
    serve(0, 0, "R2 self-test");
    serve(2, 0, "R2 calendar skipped");
    serve(3, 0, "R2 training");
    waitIdle();
    chk(calSeen == 0, "R2 no calendar request", calSeen, 0);
    chk(linkUp, "R2 link up", linkUp, 1);
    chk({rxStatEn, rxIfEn, txStatEn, txIfEn} == 4'b1100, "R4 rx-only enables",
        {rxStatEn, rxIfEn, txStatEn, txIfEn}, 12);
  endtask

  task automatic t_busy_ignore();
    request(1, 2'b11, 8);
    serve(0, 0, "R9 self-test");
    serve(1, 0, "R9 calendar");
    @(negedge clk);
    startReq = 1; restartReq = 1;
    @(negedge clk);
    startReq = 0; restartReq = 0;
    @(negedge clk);
    chk(stepReq == 4'b0100, "R9 request ignored while busy", stepReq, 4);
    chk(calLen == 8, "R9 config untouched", calLen, 8);
    serve(2, 0, "R9 clock detect");
    serve(3, 0, "R9 training");
    waitIdle();
    chk(linkUp, "R9 completes", linkUp, 1);
  endtask

  task automatic t_train_error();
    request(1, 2'b11, 8);
    serve(0, 0, "R3 self-test");
    serve(1, 0, "R3 calendar");
    serve(2, 0, "R3 clock detect");
    serve(3, 1, "R3 training fails");
    chk(!busy && errCode == 4 && !linkUp, "R3 abort code 4", errCode, 4);
    repeat (5) @(negedge clk);
    chk(stepReq == 0 && {rxStatEn, txStatEn} == 0, "R3 no later phase",
        {stepReq, rxStatEn, txStatEn}, 0);
  endtask

  task automatic t_selftest_error();
    request(0, 2'b10, 2);
    chk(errCode == 0 && busy, "R12 error cleared", errCode, 0);
    serve(0, 1, "R3 self-test fails");
    chk(errCode == 1 && !busy, "R3 abort code 1", errCode, 1);
  endtask

  task automatic t_sync_timeout();
    calLocked = 0;
    request(1, 2'b10, 6);
    serve(0, 0, "R8 self-test");
    serve(1, 0, "R8 calendar");
    serve(2, 0, "R8 clock detect");
    serve(3, 0, "R8 training");
    repeat (SYNC_TO / 2) @(negedge clk);
    chk(busy && txStatEn && !txIfEn, "R7 waiting for lock", {busy, txStatEn, txIfEn}, 6);
    waitIdle();
    chk(errCode == 5 && !linkUp, "R8 timeout code 5", errCode, 5);
    chk(txStatEn && !txIfEn && !rxIfEn, "R8 enables after timeout",
        {txStatEn, txIfEn, rxIfEn}, 4);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_full_duplex();
    t_restart_rx();
    t_busy_ignore();
    t_train_error();
    t_selftest_error();
    t_sync_timeout();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule